// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block runs the microsequence that enters a trap or interrupt handler in a 16-bit CPU with kernel, supervisor and user modes. When a request arrives it latches the current processor status word (PS) and the return PC. It then reads the new PC and PS from the two-word vector in kernel space. The old PS and PC are pushed onto the stack of the mode that the new PS selects, and the block hands the new PC, PS and stack pointer to the register file in a single write pulse.

Either push can be refused by the memory system, through a stack-limit abort or an MMU abort. When that happens the block starts a second entry flow. This recovery flow goes through the stack-error vector when the refused push targeted the kernel stack, and through the MMU-fault vector when it targeted a supervisor or user stack. The recovery frame always holds the PS and PC latched when the first flow began, and never the words fetched from the failed vector.

A status flag marks that a flow is under way, so a fault during recovery can be told apart from a fault during normal entry. A fault during recovery stops the CPU. The instruction unit can also ask for a red-zone stack error directly. That request enters through the stack-error vector on the emergency stack and, when flagged, records an MMU fault page.

Top module: `trap_vector_seq`

## Requirements
- R1: The frame pushed by a completed flow holds the `ps_in` and `pc_in` values present in the cycle the request was accepted.
- R2: The PS is written first, to SP-2, and the PC second, to SP-4. SP is the stack pointer of the mode in bits [15:14] of the vector PS (00 kernel, 01 supervisor, other values user). The writes carry that mode on `mem_mode`. The final SP equals SP-4 and is written for that mode.
- R3: The new PC is read from vector address V and the new PS from V+2, both with `mem_mode` = 00. The new PS equals the vector PS with bits [13:12] replaced by bits [15:14] of the latched PS.
- R4: A push refused with a stack-limit abort, or a push refused while targeting the kernel stack, restarts entry through vector address 4. That flow uses an emergency SP of 4, so the frame lands at addresses 2 and 0 and the final kernel SP is 0. The frame holds the originally latched PS and PC.
- R5: An MMU abort on a push to a supervisor or user stack restarts entry through vector address 160 (octal 240). The kernel stack receives exactly one frame, and the final kernel SP is its starting value minus 4.
- R6: The final PC, PS and SP after recovery are the same whether the first or the second push was refused.
- R7: `in_flow` is high from the cycle after a request is accepted until the register-file write, and low in the cycle of that write. After a recovered flow completes, a later fault is again recovered and does not stop the CPU.
- R8: A refused push during a recovery flow sets `halted`. After that the block issues no register-file write and no memory request until reset.
- R9: A red-zone request enters through vector 4 on the emergency SP. When `red_mmu` is high, `mmu_nr` becomes 1 and `mmu_page` takes `red_page`. When `red_mmu` is low, both keep their values.
- R10: After reset `busy`, `in_flow`, `halted`, `mem_req`, `rf_wr` and `mmu_nr` are 0.
- R11: A memory request keeps its address and direction unchanged until `mem_ack`. A refused push is never followed by a register-file write in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap or interrupt request, taken when idle |
| trap_vec | input | VW | Vector byte address of the request |
| red_req | input | 1 | Red-zone stack error request, takes priority over trap_req |
| red_mmu | input | 1 | The red-zone destination also faulted in the MMU |
| red_page | input | PGW | Page number of that MMU fault |
| ps_in | input | DW | Current PS |
| pc_in | input | DW | Return PC |
| sp_kern | input | DW | Kernel stack pointer |
| sp_super | input | DW | Supervisor stack pointer |
| sp_user | input | DW | User stack pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a push, 0 for a vector read |
| mem_addr | output | DW | Byte address |
| mem_wdata | output | DW | Push data |
| mem_mode | output | 2 | Address space mode of the access |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_abort_stk | input | 1 | Push refused by stack limit, valid with mem_ack |
| mem_abort_mmu | input | 1 | Push refused by MMU, valid with mem_ack |
| rf_wr | output | 1 | One-cycle register-file write strobe |
| rf_ps | output | DW | New PS |
| rf_pc | output | DW | New PC |
| rf_sp_mode | output | 2 | Mode whose SP is written |
| rf_sp | output | DW | New SP value |
| busy | output | 1 | Sequencer active |
| in_flow | output | 1 | A vector flow is in progress |
| halted | output | 1 | Fault during recovery, CPU stopped |
| mmu_nr | output | 1 | Recorded MMU non-resident fault |
| mmu_page | output | PGW | Recorded MMU fault page |

## Verification
Entry is exercised with clean traps whose vector PS selects the kernel stack and, separately, the user stack. These runs tell apart the stack selection and the previous-mode insertion. Stack-limit refusals on the first and on the second kernel push, and MMU refusals on the first user push and the second supervisor push, show whether the recovery frame comes from the latched PS and PC rather than from the vector words. They also show whether the vector-4 and vector-240 paths pick the right stack. Red-zone requests with and without the MMU flag separate recording from holding, and a double refusal separates the one allowed recovery level from a halt. Every push is compared, as it happens, against a model queue of expected address, data and mode.

// File: rtl/vf_pkg.sv
package vf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RDPC, ST_RDPS, ST_PUSH_PS, ST_PUSH_PC, ST_LOAD, ST_HALT
  } vf_state_e;

  localparam logic [1:0] MODE_KERN  = 2'b00;
  localparam logic [1:0] MODE_SUPER = 2'b01;
  localparam logic [1:0] MODE_USER  = 2'b11;
endpackage

// File: rtl/vf_capture.sv
// Holds the PS and PC seen when a flow is first accepted; recovery flows
// never reload it.
module vf_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ps_in,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] ps_q,
  output logic [DW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q <= '0;
      pc_q <= '0;
    end else if (load) begin
      ps_q <= ps_in;
      pc_q <= pc_in;
    end
  end
endmodule

// File: rtl/vf_spsel.sv
// Stack pointer base for the push pair: emergency value or per-mode SP.
module vf_spsel #(
  parameter int          DW       = 16,
  parameter int unsigned EMERG_SP = 4
) (
  input  logic          emerg,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] sp_k,
  input  logic [DW-1:0] sp_s,
  input  logic [DW-1:0] sp_u,
  output logic [DW-1:0] sp_base
);
  always_comb begin
    if (emerg) sp_base = DW'(EMERG_SP);
    else begin
      case (mode)
        vf_pkg::MODE_KERN:  sp_base = sp_k;
        vf_pkg::MODE_SUPER: sp_base = sp_s;
        default:            sp_base = sp_u;
      endcase
    end
  end
endmodule

// File: rtl/trap_vector_seq.sv
module trap_vector_seq #(
  parameter int          DW       = 16,
  parameter int          VW       = 9,
  parameter int          PGW      = 3,
  parameter int unsigned VEC_STK  = 4,
  parameter int unsigned VEC_MMU  = 160,
  parameter int unsigned EMERG_SP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trap_req,
  input  logic [VW-1:0]  trap_vec,
  input  logic           red_req,
  input  logic           red_mmu,
  input  logic [PGW-1:0] red_page,
  input  logic [DW-1:0]  ps_in,
  input  logic [DW-1:0]  pc_in,
  input  logic [DW-1:0]  sp_kern,
  input  logic [DW-1:0]  sp_super,
  input  logic [DW-1:0]  sp_user,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [1:0]     mem_mode,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_abort_stk,
  input  logic           mem_abort_mmu,
  output logic           rf_wr,
  output logic [DW-1:0]  rf_ps,
  output logic [DW-1:0]  rf_pc,
  output logic [1:0]     rf_sp_mode,
  output logic [DW-1:0]  rf_sp,
  output logic           busy,
  output logic           in_flow,
  output logic           halted,
  output logic           mmu_nr,
  output logic [PGW-1:0] mmu_page
);
  import vf_pkg::*;

  localparam int            CUR_LSB  = DW - 2;
  localparam int            PRV_LSB  = DW - 4;
  localparam logic [DW-1:0] PRV_MASK = DW'(3) << PRV_LSB;
  localparam logic [DW-1:0] STK_VEC  = DW'(VEC_STK);
  localparam logic [DW-1:0] MMU_VEC  = DW'(VEC_MMU);

  vf_state_e     st;
  logic [DW-1:0] vec_q, newpc_q, newps_q, sp_q;
  logic [1:0]    push_mode_q;
  logic          in_rec_q, emerg_q;

  logic          start_trap, start_red, cap_ld, push_abort, rec_emerg;
  logic [1:0]    sel_mode;
  logic [DW-1:0] ps_cap, pc_cap, sp_base, rec_vec, prv_bits;

  assign start_red  = (st == ST_IDLE) && red_req;
  assign start_trap = (st == ST_IDLE) && trap_req && !red_req;
  assign cap_ld     = start_red || start_trap;
  assign push_abort = mem_ack && (mem_abort_stk || mem_abort_mmu);
  assign sel_mode   = emerg_q ? MODE_KERN : mem_rdata[CUR_LSB +: 2];
  assign rec_emerg  = (push_mode_q == MODE_KERN) || mem_abort_stk;
  assign rec_vec    = rec_emerg ? STK_VEC : MMU_VEC;
  assign prv_bits   = {{(DW-2){1'b0}}, ps_cap[CUR_LSB +: 2]} << PRV_LSB;

  vf_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .load(cap_ld),
    .ps_in(ps_in), .pc_in(pc_in), .ps_q(ps_cap), .pc_q(pc_cap)
  );

  vf_spsel #(.DW(DW), .EMERG_SP(EMERG_SP)) u_sp (
    .emerg(emerg_q), .mode(sel_mode),
    .sp_k(sp_kern), .sp_s(sp_super), .sp_u(sp_user), .sp_base(sp_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      vec_q       <= '0;
      newpc_q     <= '0;
      newps_q     <= '0;
      sp_q        <= '0;
      push_mode_q <= MODE_KERN;
      in_rec_q    <= 1'b0;
      emerg_q     <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_mode    <= MODE_KERN;
      rf_wr       <= 1'b0;
      rf_ps       <= '0;
      rf_pc       <= '0;
      rf_sp_mode  <= MODE_KERN;
      rf_sp       <= '0;
      busy        <= 1'b0;
      in_flow     <= 1'b0;
      halted      <= 1'b0;
      mmu_nr      <= 1'b0;
      mmu_page    <= '0;
    end else begin
      rf_wr <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cap_ld) begin
            busy     <= 1'b1;
            in_flow  <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_mode <= MODE_KERN;
            st       <= ST_RDPC;
            if (start_red) begin
              vec_q    <= STK_VEC;
              mem_addr <= STK_VEC;
              emerg_q  <= 1'b1;
              in_rec_q <= 1'b1;
              if (red_mmu) begin
                mmu_nr   <= 1'b1;
                mmu_page <= red_page;
              end
            end else begin
              vec_q    <= {{(DW-VW){1'b0}}, trap_vec};
              mem_addr <= {{(DW-VW){1'b0}}, trap_vec};
              emerg_q  <= 1'b0;
              in_rec_q <= 1'b0;
            end
          end
        end
        ST_RDPC: begin
          if (mem_ack) begin
            newpc_q  <= mem_rdata;
            mem_addr <= vec_q + DW'(2);
            st       <= ST_RDPS;
          end
        end
        ST_RDPS: begin
          if (mem_ack) begin
            newps_q     <= mem_rdata;
            push_mode_q <= sel_mode;
            sp_q        <= sp_base;
            mem_we      <= 1'b1;
            mem_mode    <= sel_mode;
            mem_addr    <= sp_base - DW'(2);
            mem_wdata   <= ps_cap;
            st          <= ST_PUSH_PS;
          end
        end
        ST_PUSH_PS, ST_PUSH_PC: begin
          if (push_abort) begin
            if (in_rec_q) begin
              halted  <= 1'b1;
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              st      <= ST_HALT;
            end else begin
              in_rec_q <= 1'b1;
              emerg_q  <= rec_emerg;
              vec_q    <= rec_vec;
              mem_we   <= 1'b0;
              mem_mode <= MODE_KERN;
              mem_addr <= rec_vec;
              st       <= ST_RDPC;
            end
          end else if (mem_ack) begin
            if (st == ST_PUSH_PS) begin
              mem_addr  <= sp_q - DW'(4);
              mem_wdata <= pc_cap;
              st        <= ST_PUSH_PC;
            end else begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              st      <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          rf_wr      <= 1'b1;
          rf_pc      <= newpc_q;
          rf_ps      <= (newps_q & ~PRV_MASK) | prv_bits;
          rf_sp_mode <= push_mode_q;
          rf_sp      <= sp_q - DW'(4);
          busy       <= 1'b0;
          in_flow    <= 1'b0;
          in_rec_q   <= 1'b0;
          emerg_q    <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/trap_vector_seq_chk.sv
module trap_vector_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [1:0]    mem_mode,
  input logic          mem_ack,
  input logic          mem_abort_stk,
  input logic          mem_abort_mmu,
  input logic          rf_wr,
  input logic          busy,
  input logic          in_flow,
  input logic          halted
);
  assert_vecread_kernel_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_mode == 2'b00));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_no_wr_after_abort_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack && (mem_abort_stk || mem_abort_mmu)) |=> !rf_wr);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !rf_wr && !mem_req));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    rf_wr |-> (!in_flow && !busy));

  assert_flow_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(in_flow) |-> busy);
endmodule

bind trap_vector_seq trap_vector_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_mode(mem_mode), .mem_ack(mem_ack),
  .mem_abort_stk(mem_abort_stk), .mem_abort_mmu(mem_abort_mmu),
  .rf_wr(rf_wr), .busy(busy), .in_flow(in_flow), .halted(halted)
);

// File: tb/test_trap_vector_seq.sv
`timescale 1ns/1ps
module test_trap_vector_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trap_req = 1'b0, red_req = 1'b0, red_mmu = 1'b0;
  logic [8:0]  trap_vec = '0;
  logic [2:0]  red_page = '0;
  logic [15:0] ps_in = '0, pc_in = '0;
  logic [15:0] sp_kern = 16'h0400, sp_super = 16'h0600, sp_user = 16'h0800;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0]  mem_mode;
  logic        mem_abort_stk = 1'b0, mem_abort_mmu = 1'b0;
  logic        rf_wr, busy, in_flow, halted, mmu_nr;
  logic [15:0] rf_ps, rf_pc, rf_sp;
  logic [1:0]  rf_sp_mode;
  logic [2:0]  mmu_page;

  int n_chk = 0, n_fail = 0;

  logic [15:0] mem_arr [0:4095];
  logic [15:0] q_a[$], q_d[$];
  logic [1:0]  q_m[$];
  string       q_t[$];
  logic [15:0] stk_a = 16'hFFFF, stk_b = 16'hFFFF, mmu_a = 16'hFFFF;
  logic [1:0]  mmu_m = 2'b00;
  logic [15:0] ea, ed;
  logic [1:0]  em;
  string       et;

  always #10 clk = ~clk;

  trap_vector_seq i_trap_vector_seq (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_vec(trap_vec),
    .red_req(red_req), .red_mmu(red_mmu), .red_page(red_page),
    .ps_in(ps_in), .pc_in(pc_in), .sp_kern(sp_kern), .sp_super(sp_super),
    .sp_user(sp_user), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_mode(mem_mode),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_abort_stk(mem_abort_stk),
    .mem_abort_mmu(mem_abort_mmu), .rf_wr(rf_wr), .rf_ps(rf_ps),
    .rf_pc(rf_pc), .rf_sp_mode(rf_sp_mode), .rf_sp(rf_sp), .busy(busy),
    .in_flow(in_flow), .halted(halted), .mmu_nr(mmu_nr), .mmu_page(mmu_page)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_push(input logic [15:0] a, input logic [15:0] d,
                             input logic [1:0] m, input string t);
    q_a.push_back(a); q_d.push_back(d); q_m.push_back(m); q_t.push_back(t);
  endtask

  // Memory and fault model, acting on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_abort_stk <= 1'b0; mem_abort_mmu <= 1'b0;
    end else begin
      mem_ack <= 1'b0; mem_abort_stk <= 1'b0; mem_abort_mmu <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          if (q_a.size() == 0) check(1'b0, "R2 unexpected push", mem_addr, 16'hFFFF);
          else begin
            ea = q_a.pop_front(); ed = q_d.pop_front();
            em = q_m.pop_front(); et = q_t.pop_front();
            check(mem_addr == ea, {et, " push addr"}, mem_addr, ea);
            check(mem_wdata == ed, {et, " push data"}, mem_wdata, ed);
            check(mem_mode == em, {et, " push mode"}, {14'd0, mem_mode}, {14'd0, em});
          end
          if (mem_mode == 2'b00 && (mem_addr == stk_a || mem_addr == stk_b))
            mem_abort_stk <= 1'b1;
          else if (mem_mode == mmu_m && mem_addr == mmu_a)
            mem_abort_mmu <= 1'b1;
          else
            mem_arr[mem_addr[12:1]] <= mem_wdata;
        end else begin
          check(mem_mode == 2'b00, "R3 vector read mode", {14'd0, mem_mode}, 16'd0);
          mem_rdata <= mem_arr[mem_addr[12:1]];
        end
      end
    end
  end

  task automatic wait_end(output bit got_wr);
    got_wr = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rf_wr) begin got_wr = 1'b1; break; end
      if (halted) break;
    end
  endtask

  task automatic start(input bit red, input logic [15:0] ps, input logic [15:0] pc,
                       input logic [8:0] vec, input bit rmmu, input logic [2:0] pg);
    @(negedge clk);
    ps_in = ps; pc_in = pc; trap_vec = vec;
    red_req = red; trap_req = !red; red_mmu = rmmu; red_page = pg;
    @(negedge clk);
    trap_req = 1'b0; red_req = 1'b0; red_mmu = 1'b0;
    ps_in = 16'hDEAD; pc_in = 16'hBEEF;
    check(in_flow == 1'b1, "R7 in_flow set", {15'd0, in_flow}, 16'd1);
  endtask

  task automatic finish_flow(input string req, input logic [15:0] xpc,
                             input logic [15:0] xps, input logic [1:0] xm,
                             input logic [15:0] xsp);
    bit got;
    wait_end(got);
    check(got, {req, " completion"}, {15'd0, got}, 16'd1);
    check(rf_pc == xpc, {req, " new PC"}, rf_pc, xpc);
    check(rf_ps == xps, {req, " new PS"}, rf_ps, xps);
    check(rf_sp_mode == xm, {req, " SP mode"}, {14'd0, rf_sp_mode}, {14'd0, xm});
    check(rf_sp == xsp, {req, " final SP"}, rf_sp, xsp);
    check(in_flow == 1'b0, "R7 in_flow cleared", {15'd0, in_flow}, 16'd0);
    check(q_a.size() == 0, {req, " all pushes seen"}, 16'(q_a.size()), 16'd0);
    stk_a = 16'hFFFF; stk_b = 16'hFFFF; mmu_a = 16'hFFFF;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit got;
    for (int i = 0; i < 4096; i++) mem_arr[i] = 16'h0000;
    mem_arr[16'h0004 >> 1] = 16'h0100; mem_arr[16'h0006 >> 1] = 16'h00A1;
    mem_arr[16'h00A0 >> 1] = 16'h0200; mem_arr[16'h00A2 >> 1] = 16'h00E0;
    mem_arr[16'h001C >> 1] = 16'h0300; mem_arr[16'h001E >> 1] = 16'h00C0;
    mem_arr[16'h0040 >> 1] = 16'h0400; mem_arr[16'h0042 >> 1] = 16'hC040;
    mem_arr[16'h0044 >> 1] = 16'h0500; mem_arr[16'h0046 >> 1] = 16'h4022;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({busy, in_flow, halted, mem_req, rf_wr, mmu_nr} == 6'b0, "R10 reset outputs",
          {10'd0, busy, in_flow, halted, mem_req, rf_wr, mmu_nr}, 16'd0);

    // R1 R2 R3: clean trap onto the kernel stack
    expect_push(16'h03FE, 16'h0061, 2'b00, "R1 R2 kernel");
    expect_push(16'h03FC, 16'h1234, 2'b00, "R1 R2 kernel");
    start(1'b0, 16'h0061, 16'h1234, 9'h01C, 1'b0, 3'd0);
    finish_flow("R2", 16'h0300, 16'h00C0, 2'b00, 16'h03FC);

    // R2 R3: user stack, previous mode from supervisor PS
    expect_push(16'h07FE, 16'h4005, 2'b11, "R2 user");
    expect_push(16'h07FC, 16'h2222, 2'b11, "R2 user");
    start(1'b0, 16'h4005, 16'h2222, 9'h040, 1'b0, 3'd0);
    finish_flow("R3", 16'h0400, 16'hD040, 2'b11, 16'h07FC);

    // R4 R6: stack-limit abort on second kernel push
    stk_a = 16'h03FC;
    expect_push(16'h03FE, 16'h0060, 2'b00, "R4 second");
    expect_push(16'h03FC, 16'h1100, 2'b00, "R4 second");
    expect_push(16'h0002, 16'h0060, 2'b00, "R4 emergency");
    expect_push(16'h0000, 16'h1100, 2'b00, "R4 emergency");
    start(1'b0, 16'h0060, 16'h1100, 9'h01C, 1'b0, 3'd0);
    finish_flow("R4", 16'h0100, 16'h00A1, 2'b00, 16'h0000);

    // R6 R7: abort on first kernel push, recovered again after prior recovery
    stk_a = 16'h03FE;
    expect_push(16'h03FE, 16'h0081, 2'b00, "R6 first");
    expect_push(16'h0002, 16'h0081, 2'b00, "R6 emergency");
    expect_push(16'h0000, 16'h1300, 2'b00, "R6 emergency");
    start(1'b0, 16'h0081, 16'h1300, 9'h01C, 1'b0, 3'd0);
    finish_flow("R6", 16'h0100, 16'h00A1, 2'b00, 16'h0000);

    // R5: MMU abort on first user push
    mmu_a = 16'h07FE; mmu_m = 2'b11;
    expect_push(16'h07FE, 16'h4003, 2'b11, "R5 user first");
    expect_push(16'h03FE, 16'h4003, 2'b00, "R5 kernel frame");
    expect_push(16'h03FC, 16'h2400, 2'b00, "R5 kernel frame");
    start(1'b0, 16'h4003, 16'h2400, 9'h040, 1'b0, 3'd0);
    finish_flow("R5", 16'h0200, 16'h10E0, 2'b00, 16'h03FC);

    // R5 R6: MMU abort on second supervisor push
    mmu_a = 16'h05FC; mmu_m = 2'b01;
    expect_push(16'h05FE, 16'h0004, 2'b01, "R5 super");
    expect_push(16'h05FC, 16'h2600, 2'b01, "R5 super");
    expect_push(16'h03FE, 16'h0004, 2'b00, "R5 kernel frame");
    expect_push(16'h03FC, 16'h2600, 2'b00, "R5 kernel frame");
    start(1'b0, 16'h0004, 16'h2600, 9'h044, 1'b0, 3'd0);
    finish_flow("R6", 16'h0200, 16'h00E0, 2'b00, 16'h03FC);

    // R9: red-zone request with MMU fault page 5
    expect_push(16'h0002, 16'h0080, 2'b00, "R9 red");
    expect_push(16'h0000, 16'h3000, 2'b00, "R9 red");
    start(1'b1, 16'h0080, 16'h3000, 9'h000, 1'b1, 3'd5);
    finish_flow("R9", 16'h0100, 16'h00A1, 2'b00, 16'h0000);
    check(mmu_nr == 1'b1, "R9 mmu_nr recorded", {15'd0, mmu_nr}, 16'd1);
    check(mmu_page == 3'd5, "R9 mmu_page recorded", {13'd0, mmu_page}, 16'd5);

    // R9: red-zone request without MMU fault leaves status unchanged
    expect_push(16'h0002, 16'h4000, 2'b00, "R9 red plain");
    expect_push(16'h0000, 16'h3100, 2'b00, "R9 red plain");
    start(1'b1, 16'h4000, 16'h3100, 9'h000, 1'b0, 3'd2);
    finish_flow("R9", 16'h0100, 16'h10A1, 2'b00, 16'h0000);
    check(mmu_page == 3'd5, "R9 mmu_page held", {13'd0, mmu_page}, 16'd5);

    // R8: fault during recovery halts
    stk_a = 16'h03FE; stk_b = 16'h0002;
    expect_push(16'h03FE, 16'h0020, 2'b00, "R8 first");
    expect_push(16'h0002, 16'h0020, 2'b00, "R8 emergency");
    start(1'b0, 16'h0020, 16'h1500, 9'h01C, 1'b0, 3'd0);
    wait_end(got);
    check(!got, "R8 no register write", {15'd0, got}, 16'd0);
    check(halted == 1'b1, "R8 halted", {15'd0, halted}, 16'd1);
    repeat (10) begin
      @(negedge clk);
      if (rf_wr || mem_req) check(1'b0, "R8 quiet after halt", {14'd0, rf_wr, mem_req}, 16'd0);
    end
    check(halted == 1'b1, "R8 halted held", {15'd0, halted}, 16'd1);
    check(q_a.size() == 0, "R8 pushes seen", 16'(q_a.size()), 16'd0);
    stk_a = 16'hFFFF; stk_b = 16'hFFFF;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(halted == 1'b0 && busy == 1'b0, "R10 reset clears halt",
          {14'd0, halted, busy}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule